// File: doc/BRIEF.md
# Level-Sensitive Interrupt Router with Acknowledge-Time Masking

The router collects `N_IRQ` level-sensitive hardware interrupt lines and delivers each to any subset of `N_CPU` processors. Each source has a mask bit, a software trigger bit and a CPU routing set. Each processor also owns two inter-processor interrupt (IPI) flags, numbered 0 and 1. The two flags behave the same way and differ only in priority. A processor finds out what to service by reading its event register. The read returns the most urgent pending source routed to that processor. The same read masks that source, so the source stays silent until software unmasks it.

Each processor has its own register port. A port is a valid-only request channel with no back-pressure: every request presented with `req_valid` high is taken at that clock edge. A read answers exactly one cycle later with `rsp_valid` and `rsp_rdata`, and the processor side must accept that response; there is no ready signal. Writes produce no response. The address space has three regions. The global region holds mask, trigger and routing state. The local window acts on the processor that owns the port. The explicit windows name a processor by number.

Top module: `irq_router`

## Requirements
- R1: After reset every hardware source is masked, all software triggers are clear, every routing set is CPU 0 only (value 1), all IPI pending and IPI mask bits are clear, `cpu_irq` is 0 and `rsp_valid` is 0.
- R2: A write of word w to 0x000+w sets the mask bits of sources 32w..32w+31 that have a 1 in the data. A write to 0x040+w clears those mask bits. Reading either address returns that mask word. When one cycle both sets and clears a bit, the bit ends up set.
- R3: Source i is pending for CPU c while (line i OR trigger i) is 1, mask i is 0 and bit c of its routing set is 1. `cpu_irq[c]` is high exactly when some source or unmasked IPI is pending for CPU c, and it follows the input lines in the same cycle.
- R4: Writes to 0x080+w and 0x0C0+w set and clear software trigger bits in the same way as R2. Reading either address returns the trigger word. A trigger holds a source pending even when its line is low. Setting a bit wins over clearing it.
- R5: Address 0x100+i holds the routing set of source i in bits [N_CPU-1:0], and the register reads back. A set of 0 routes the source to no CPU. If several ports write the same set in one cycle, the lowest-numbered port wins.
- R6: A read of the event register (offset 0 in a CPU window) returns {type[15:0], number[15:0]}. The types are 0 for nothing pending, 4 for an IPI and 1 for a hardware source. IPI 0 ranks first, then IPI 1, then hardware sources in increasing number order. The result appears one cycle after the read.
- R7: A hardware source returned by an event read has its mask bit set at that clock edge. It is not reported again until its mask bit is cleared.
- R8: CPU window offset 1 sets IPI pending bits from data bits [1:0]. Offset 2 clears them. Offsets 3 and 4 set and clear the IPI mask bits. Offsets 1 and 2 read back the pending bits, and offsets 3 and 4 read back the mask bits. An event read that returns an IPI clears its pending bit and sets its mask bit. A send in the same cycle wins over a clear.
- R9: When several ports read event registers in the same cycle, they are served in increasing port order. A source handed to one port is not handed to a later port in that cycle.
- R10: The local window at 0x400+r acts on the CPU that owns the port. The explicit window at 0x800+16c+r acts on CPU c. An explicit window with c >= N_CPU reads 0 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | N_IRQ | Hardware interrupt levels |
| req_valid | input | N_CPU | Request strobe, one per CPU port |
| req_write | input | N_CPU | 1 = write, 0 = read |
| req_addr | input | N_CPU*12 | Word address per port |
| req_wdata | input | N_CPU*32 | Write data per port |
| rsp_valid | output | N_CPU | Read response strobe per port |
| rsp_rdata | output | N_CPU*32 | Read data per port |
| cpu_irq | output | N_CPU | Interrupt request per CPU |

## Verification
The hardest case to reach is contention at acknowledge time. It takes a source routed to several CPUs, or two windows aimed at the same CPU, with event reads on more than one port in the same cycle. An IPI send or mask write on the same edge makes it harder still. Directed steps build the shared-routing and same-cycle-read case on purpose. The random phase then sets every port to issue event reads, explicit-window accesses and conflicting mask writes at high density. A bench model resolves the reads in port order and predicts every response and `cpu_irq` level.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [15:0] EVT_NONE = 16'd0;
  localparam logic [15:0] EVT_HW   = 16'd1;
  localparam logic [15:0] EVT_IPI  = 16'd4;

  localparam logic [3:0] CREG_EVENT    = 4'd0;
  localparam logic [3:0] CREG_IPI_SET  = 4'd1;
  localparam logic [3:0] CREG_IPI_CLR  = 4'd2;
  localparam logic [3:0] CREG_IMSK_SET = 4'd3;
  localparam logic [3:0] CREG_IMSK_CLR = 4'd4;

  function automatic logic [DW-1:0] evt_word(input logic [15:0] kind, input logic [15:0] num);
    return {kind, num};
  endfunction
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs #(
  parameter int N_IRQ = 64,
  parameter int N_CPU = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IRQ-1:0]       irq_lines,
  input  logic [N_IRQ-1:0]       mset,
  input  logic [N_IRQ-1:0]       mclr,
  input  logic [N_IRQ-1:0]       sset,
  input  logic [N_IRQ-1:0]       sclr,
  input  logic [N_IRQ-1:0]       ack,
  input  logic [N_IRQ-1:0]       aff_we,
  input  logic [N_IRQ*N_CPU-1:0] aff_wd,
  output logic [N_IRQ-1:0]       mask,
  output logic [N_IRQ-1:0]       trig,
  output logic [N_IRQ*N_CPU-1:0] aff,
  output logic [N_CPU*N_IRQ-1:0] avail
);
  logic [N_IRQ-1:0] level;
  assign level = irq_lines | trig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '1;
      trig <= '0;
    end else begin
      mask <= (mask & ~mclr) | mset | ack;
      trig <= (trig & ~sclr) | sset;
    end
  end

  for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)
        aff[gi*N_CPU +: N_CPU] <= N_CPU'(1);
      else if (aff_we[gi])
        aff[gi*N_CPU +: N_CPU] <= aff_wd[gi*N_CPU +: N_CPU];
    end
    for (genvar gc = 0; gc < N_CPU; gc++) begin : g_route
      assign avail[gc*N_IRQ + gi] = level[gi] & ~mask[gi] & aff[gi*N_CPU + gc];
    end
  end

  AST_ACK_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack) |=> ((mask & $past(ack)) == $past(ack))); // R7
  AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mclr & ~mset & ~ack)) |=> ((mask & $past(mclr & ~mset & ~ack)) == '0)); // R2
  AST_TRIG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|sset) |=> ((trig & $past(sset)) == $past(sset))); // R4
endmodule

// File: rtl/irq_ipi_bank.sv
module irq_ipi_bank #(
  parameter int N_CPU = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CPU*2-1:0] set,
  input  logic [N_CPU*2-1:0] clr,
  input  logic [N_CPU*2-1:0] mset,
  input  logic [N_CPU*2-1:0] mclr,
  input  logic [N_CPU*2-1:0] ack,
  output logic [N_CPU*2-1:0] pend,
  output logic [N_CPU*2-1:0] mask,
  output logic [N_CPU*2-1:0] avail
);
  for (genvar gc = 0; gc < N_CPU; gc++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[gc*2 +: 2] <= 2'b00;
        mask[gc*2 +: 2] <= 2'b00;
      end else begin
        pend[gc*2 +: 2] <= (pend[gc*2 +: 2] & ~clr[gc*2 +: 2] & ~ack[gc*2 +: 2]) | set[gc*2 +: 2];
        mask[gc*2 +: 2] <= (mask[gc*2 +: 2] & ~mclr[gc*2 +: 2]) | mset[gc*2 +: 2] | ack[gc*2 +: 2];
      end
    end
  end
  assign avail = pend & ~mask;

  AST_IPI_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack & ~set)) |=> (((pend & $past(ack & ~set)) == '0) &&
                         ((mask & $past(ack)) == $past(ack)))); // R8
endmodule

// File: rtl/irq_ack_chain.sv
module irq_ack_chain
  import irq_router_pkg::*;
#(
  parameter int N_IRQ = 64,
  parameter int N_CPU = 4,
  parameter int CW    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CPU-1:0]       rd_en,
  input  logic [N_CPU*CW-1:0]    rd_tgt,
  input  logic [N_CPU*N_IRQ-1:0] hw_avail,
  input  logic [N_CPU*2-1:0]     ipi_avail,
  output logic [N_CPU*DW-1:0]    evt,
  output logic [N_IRQ-1:0]       ack_hw,
  output logic [N_CPU*2-1:0]     ack_ipi
);
  logic [N_IRQ-1:0]       taken_hw;
  logic [N_CPU*2-1:0]     taken_ipi;
  logic [N_CPU*N_IRQ-1:0] port_hw;
  logic [N_IRQ-1:0]       cand_hw;
  logic [1:0]             cand_ip;
  int                     t;
  int                     n;

  function automatic int lowest_set(input logic [N_IRQ-1:0] v);
    int r;
    r = 0;
    for (int i = N_IRQ - 1; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  always_comb begin
    taken_hw  = '0;
    taken_ipi = '0;
    port_hw   = '0;
    evt       = '0;
    cand_hw   = '0;
    cand_ip   = '0;
    t         = 0;
    n         = 0;
    for (int p = 0; p < N_CPU; p++) begin
      if (rd_en[p]) begin
        t       = int'(rd_tgt[p*CW +: CW]);
        cand_ip = ipi_avail[t*2 +: 2] & ~taken_ipi[t*2 +: 2];
        cand_hw = hw_avail[t*N_IRQ +: N_IRQ] & ~taken_hw;
        if (cand_ip[0]) begin
          evt[p*DW +: DW]  = evt_word(EVT_IPI, 16'd0);
          taken_ipi[t*2]   = 1'b1;
        end else if (cand_ip[1]) begin
          evt[p*DW +: DW]  = evt_word(EVT_IPI, 16'd1);
          taken_ipi[t*2+1] = 1'b1;
        end else if (|cand_hw) begin
          n = lowest_set(cand_hw);
          evt[p*DW +: DW]      = evt_word(EVT_HW, 16'(n));
          taken_hw[n]          = 1'b1;
          port_hw[p*N_IRQ + n] = 1'b1;
        end
      end
    end
  end

  assign ack_hw  = taken_hw;
  assign ack_ipi = taken_ipi;

  AST_HW_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(port_hw) == $countones(ack_hw)); // R9
  for (genvar gp = 0; gp < N_CPU; gp++) begin : g_chk
    AST_EVT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[gp*DW+16 +: 16] == EVT_NONE) || (evt[gp*DW+16 +: 16] == EVT_HW) ||
      (evt[gp*DW+16 +: 16] == EVT_IPI)); // R6
    AST_IDLE_PORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[gp] |-> (evt[gp*DW +: DW] == '0)); // R6
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N_IRQ = 64,
  parameter int N_CPU = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_IRQ-1:0]    irq_lines,
  input  logic [N_CPU-1:0]    req_valid,
  input  logic [N_CPU-1:0]    req_write,
  input  logic [N_CPU*AW-1:0] req_addr,
  input  logic [N_CPU*DW-1:0] req_wdata,
  output logic [N_CPU-1:0]    rsp_valid,
  output logic [N_CPU*DW-1:0] rsp_rdata,
  output logic [N_CPU-1:0]    cpu_irq
);
  localparam int CW = (N_CPU > 1) ? $clog2(N_CPU) : 1;

  logic [N_IRQ-1:0]       mask, trig, ack_hw;
  logic [N_IRQ*N_CPU-1:0] aff, aff_wd;
  logic [N_CPU*N_IRQ-1:0] hw_avail;
  logic [N_IRQ-1:0]       mset_v, mclr_v, sset_v, sclr_v, aff_we;
  logic [N_CPU*2-1:0]     ipi_set, ipi_clr, imsk_set, imsk_clr, ack_ipi;
  logic [N_CPU*2-1:0]     ipi_pend, ipi_mask, ipi_avail;
  logic [N_CPU-1:0]       evt_rd;
  logic [N_CPU*CW-1:0]    evt_tgt;
  logic [N_CPU*DW-1:0]    evt_out;

  logic [AW-1:0] p_addr [N_CPU];
  logic [DW-1:0] p_wd   [N_CPU];
  logic [DW-1:0] p_rd   [N_CPU];
  logic [CW-1:0] p_tgt  [N_CPU];
  logic [3:0]    p_creg [N_CPU];
  logic [N_CPU-1:0] p_glob, p_cpu_ok;

  for (genvar gp = 0; gp < N_CPU; gp++) begin : g_port
    assign p_addr[gp] = req_addr[gp*AW +: AW];
    assign p_wd[gp]   = req_wdata[gp*DW +: DW];
    assign p_glob[gp] = req_valid[gp] && (p_addr[gp][11:10] == 2'd0);
    assign p_tgt[gp]  = (p_addr[gp][11:10] == 2'd1) ? CW'(gp) : CW'(p_addr[gp][7:4]);
    assign p_cpu_ok[gp] = req_valid[gp] &&
      ((p_addr[gp][11:10] == 2'd1) ||
       ((p_addr[gp][11:10] == 2'd2) && (int'(p_addr[gp][7:4]) < N_CPU)));
    assign p_creg[gp] = p_addr[gp][3:0];
    assign evt_rd[gp] = p_cpu_ok[gp] && !req_write[gp] && (p_creg[gp] == CREG_EVENT);
    assign evt_tgt[gp*CW +: CW] = p_tgt[gp];

    always_comb begin
      p_rd[gp] = '0;
      if (p_glob[gp] && p_addr[gp][9:8] == 2'd0) begin
        for (int i = 0; i < N_IRQ; i++)
          if (p_addr[gp][5:0] == 6'(i / 32))
            p_rd[gp][i % 32] = p_addr[gp][7] ? trig[i] : mask[i];
      end else if (p_glob[gp] && p_addr[gp][9:8] == 2'd1) begin
        for (int i = 0; i < N_IRQ; i++)
          if (p_addr[gp][7:0] == 8'(i))
            p_rd[gp][N_CPU-1:0] = aff[i*N_CPU +: N_CPU];
      end else if (p_cpu_ok[gp]) begin
        case (p_creg[gp])
          CREG_EVENT:                  p_rd[gp] = evt_out[gp*DW +: DW];
          CREG_IPI_SET, CREG_IPI_CLR:  p_rd[gp][1:0] = ipi_pend[int'(p_tgt[gp])*2 +: 2];
          CREG_IMSK_SET, CREG_IMSK_CLR: p_rd[gp][1:0] = ipi_mask[int'(p_tgt[gp])*2 +: 2];
          default:                     p_rd[gp] = '0;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsp_valid[gp] <= 1'b0;
        rsp_rdata[gp*DW +: DW] <= '0;
      end else begin
        rsp_valid[gp] <= req_valid[gp] && !req_write[gp];
        if (req_valid[gp] && !req_write[gp])
          rsp_rdata[gp*DW +: DW] <= p_rd[gp];
      end
    end
  end

  always_comb begin
    mset_v = '0; mclr_v = '0; sset_v = '0; sclr_v = '0;
    aff_we = '0; aff_wd = '0;
    ipi_set = '0; ipi_clr = '0; imsk_set = '0; imsk_clr = '0;
    for (int p = N_CPU - 1; p >= 0; p--) begin
      if (p_glob[p] && req_write[p] && p_addr[p][9:8] == 2'd1) begin
        for (int i = 0; i < N_IRQ; i++) begin
          if (p_addr[p][7:0] == 8'(i)) begin
            aff_we[i] = 1'b1;
            aff_wd[i*N_CPU +: N_CPU] = p_wd[p][N_CPU-1:0];
          end
        end
      end
    end
    for (int p = 0; p < N_CPU; p++) begin
      if (p_glob[p] && req_write[p] && p_addr[p][9:8] == 2'd0) begin
        for (int i = 0; i < N_IRQ; i++) begin
          if (p_addr[p][5:0] == 6'(i / 32) && p_wd[p][i % 32]) begin
            case (p_addr[p][7:6])
              2'd0: mset_v[i] = 1'b1;
              2'd1: mclr_v[i] = 1'b1;
              2'd2: sset_v[i] = 1'b1;
              default: sclr_v[i] = 1'b1;
            endcase
          end
        end
      end
      if (p_cpu_ok[p] && req_write[p]) begin
        case (p_creg[p])
          CREG_IPI_SET:  ipi_set[int'(p_tgt[p])*2 +: 2]  = ipi_set[int'(p_tgt[p])*2 +: 2]  | p_wd[p][1:0];
          CREG_IPI_CLR:  ipi_clr[int'(p_tgt[p])*2 +: 2]  = ipi_clr[int'(p_tgt[p])*2 +: 2]  | p_wd[p][1:0];
          CREG_IMSK_SET: imsk_set[int'(p_tgt[p])*2 +: 2] = imsk_set[int'(p_tgt[p])*2 +: 2] | p_wd[p][1:0];
          CREG_IMSK_CLR: imsk_clr[int'(p_tgt[p])*2 +: 2] = imsk_clr[int'(p_tgt[p])*2 +: 2] | p_wd[p][1:0];
          default: ;
        endcase
      end
    end
  end

  irq_src_regs #(.N_IRQ(N_IRQ), .N_CPU(N_CPU)) i_src (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .mset(mset_v), .mclr(mclr_v), .sset(sset_v), .sclr(sclr_v), .ack(ack_hw),
    .aff_we(aff_we), .aff_wd(aff_wd),
    .mask(mask), .trig(trig), .aff(aff), .avail(hw_avail)
  );

  irq_ipi_bank #(.N_CPU(N_CPU)) i_ipi (
    .clk(clk), .rst_n(rst_n), .set(ipi_set), .clr(ipi_clr),
    .mset(imsk_set), .mclr(imsk_clr), .ack(ack_ipi),
    .pend(ipi_pend), .mask(ipi_mask), .avail(ipi_avail)
  );

  irq_ack_chain #(.N_IRQ(N_IRQ), .N_CPU(N_CPU), .CW(CW)) i_chain (
    .clk(clk), .rst_n(rst_n), .rd_en(evt_rd), .rd_tgt(evt_tgt),
    .hw_avail(hw_avail), .ipi_avail(ipi_avail),
    .evt(evt_out), .ack_hw(ack_hw), .ack_ipi(ack_ipi)
  );

  for (genvar gc = 0; gc < N_CPU; gc++) begin : g_out
    assign cpu_irq[gc] = (|hw_avail[gc*N_IRQ +: N_IRQ]) | (|ipi_avail[gc*2 +: 2]);
  end

  AST_ACK_ONLY_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hw & mask) == '0); // R7
  AST_ACK_ONLY_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hw & ~(irq_lines | trig)) == '0); // R3
endmodule

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;
  localparam int NI = 64;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0]    irq_lines = '0;
  logic [NC-1:0]    req_valid = '0;
  logic [NC-1:0]    req_write = '0;
  logic [NC*12-1:0] req_addr  = '0;
  logic [NC*32-1:0] req_wdata = '0;
  logic [NC-1:0]    rsp_valid;
  logic [NC*32-1:0] rsp_rdata;
  logic [NC-1:0]    cpu_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [NI-1:0] m_mask, m_trig;
  logic [NC-1:0] m_aff [NI];
  logic [1:0]    m_ip [NC];
  logic [1:0]    m_im [NC];

  irq_router #(.N_IRQ(NI), .N_CPU(NC)) i_irq_router (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cpu_irq(cpu_irq)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NI-1:0] route(int c);
    logic [NI-1:0] v;
    for (int i = 0; i < NI; i++) v[i] = m_aff[i][c];
    return v;
  endfunction

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] r;
    for (int c = 0; c < NC; c++)
      r[c] = (|((irq_lines | m_trig) & ~m_mask & route(c))) | (|(m_ip[c] & ~m_im[c]));
    return r;
  endfunction

  task automatic put(int p, bit wr, logic [11:0] a, logic [31:0] d);
    req_valid[p] = 1'b1;
    req_write[p] = wr;
    req_addr[p*12 +: 12] = a;
    req_wdata[p*32 +: 32] = d;
  endtask

  task automatic step(string tag);
    logic [NI-1:0] mset = '0, mclr = '0, sset = '0, sclr = '0, thw = '0;
    logic [1:0] is [NC], ic [NC], ms [NC], mc [NC], tip [NC];
    logic [31:0] er [NC];
    logic [NC-1:0] ev = '0;
    for (int c = 0; c < NC; c++) begin
      is[c] = 0; ic[c] = 0; ms[c] = 0; mc[c] = 0; tip[c] = 0;
    end
    for (int p = 0; p < NC; p++) begin
      logic [11:0] a;
      logic [31:0] d;
      int t;
      er[p] = '0;
      if (!req_valid[p]) continue;
      a = req_addr[p*12 +: 12];
      d = req_wdata[p*32 +: 32];
      ev[p] = !req_write[p];
      t = -1;
      if (a[11:10] == 2'd1) t = p;
      else if (a[11:10] == 2'd2 && int'(a[7:4]) < NC) t = int'(a[7:4]);
      if (a[11:10] == 2'd0 && a[9:8] == 2'd0) begin
        for (int i = 0; i < NI; i++) begin
          if (i / 32 != int'(a[5:0])) continue;
          if (!req_write[p]) er[p][i % 32] = a[7] ? m_trig[i] : m_mask[i];
          else if (d[i % 32]) begin
            case (a[7:6])
              2'd0: mset[i] = 1; 2'd1: mclr[i] = 1;
              2'd2: sset[i] = 1; default: sclr[i] = 1;
            endcase
          end
        end
      end else if (a[11:10] == 2'd0 && a[9:8] == 2'd1) begin
        if (!req_write[p] && int'(a[7:0]) < NI) er[p][NC-1:0] = m_aff[a[7:0]];
      end else if (t >= 0) begin
        if (req_write[p]) begin
          case (a[3:0])
            4'd1: is[t] |= d[1:0]; 4'd2: ic[t] |= d[1:0];
            4'd3: ms[t] |= d[1:0]; 4'd4: mc[t] |= d[1:0];
            default: ;
          endcase
        end else begin
          case (a[3:0])
            4'd0: begin
              logic [1:0] cip;
              logic [NI-1:0] chw;
              cip = m_ip[t] & ~m_im[t] & ~tip[t];
              chw = (irq_lines | m_trig) & ~m_mask & route(t) & ~thw;
              if (cip[0]) begin er[p] = 32'h0004_0000; tip[t][0] = 1; end
              else if (cip[1]) begin er[p] = 32'h0004_0001; tip[t][1] = 1; end
              else begin
                for (int i = 0; i < NI; i++) if (chw[i]) begin
                  er[p] = 32'h0001_0000 | i; thw[i] = 1; break;
                end
              end
            end
            4'd1, 4'd2: er[p][1:0] = m_ip[t];
            4'd3, 4'd4: er[p][1:0] = m_im[t];
            default: ;
          endcase
        end
      end
    end
    for (int p = NC - 1; p >= 0; p--) begin
      logic [11:0] a;
      a = req_addr[p*12 +: 12];
      if (req_valid[p] && req_write[p] && a[11:8] == 4'd1 && int'(a[7:0]) < NI)
        m_aff[a[7:0]] = req_wdata[p*32 +: NC];
    end
    m_mask = (m_mask & ~mclr) | mset | thw;
    m_trig = (m_trig & ~sclr) | sset;
    for (int c = 0; c < NC; c++) begin
      m_ip[c] = (m_ip[c] & ~ic[c] & ~tip[c]) | is[c];
      m_im[c] = (m_im[c] & ~mc[c]) | ms[c] | tip[c];
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = '0;
    for (int p = 0; p < NC; p++) begin
      chk(tag, 32'(rsp_valid[p]), 32'(ev[p]), "rsp_valid");
      if (ev[p]) chk(tag, rsp_rdata[p*32 +: 32], er[p], "rsp_rdata");
    end
    chk("R3", 32'(cpu_irq), 32'(exp_irq()), "cpu_irq");
  endtask

  function automatic logic [31:0] rd(int p);
    return rsp_rdata[p*32 +: 32];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20514));
    m_mask = '1; m_trig = '0;
    for (int i = 0; i < NI; i++) m_aff[i] = 1;
    for (int c = 0; c < NC; c++) begin m_ip[c] = 0; m_im[c] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", 32'(cpu_irq), 0, "cpu_irq after reset");
    chk("R1", 32'(rsp_valid), 0, "rsp_valid after reset");
    put(0, 0, 12'h000, 0); put(1, 0, 12'h105, 0); put(2, 0, 12'h0C1, 0);
    step("R1");
    chk("R1", rd(0), 32'hFFFF_FFFF, "mask word 0");
    chk("R1", rd(1), 32'h1, "routing of source 5");
    chk("R1", rd(2), 32'h0, "trigger word 1");

    irq_lines[3] = 1'b1;
    put(0, 1, 12'h040, 32'h8); step("R2");
    chk("R3", 32'(cpu_irq), 32'h1, "line 3 reaches CPU0 only");
    put(0, 0, 12'h400, 0); step("R6");
    chk("R6", rd(0), 32'h0001_0003, "event hw 3");
    chk("R7", 32'(cpu_irq), 32'h0, "acked source masked");
    put(0, 0, 12'h040, 0); step("R7");
    chk("R7", 32'(rd(0)[3]), 1, "mask bit 3 set by ack");

    put(0, 1, 12'h081, 32'h100); put(1, 1, 12'h128, 32'h4); put(2, 1, 12'h041, 32'h100);
    step("R4");
    chk("R5", 32'(cpu_irq), 32'h4, "software-triggered 40 routed to CPU2");
    put(1, 0, 12'h820, 0); step("R10");
    chk("R10", rd(1), 32'h0001_0028, "explicit window of CPU2");
    put(0, 1, 12'h041, 32'h100); step("R4");
    chk("R4", 32'(cpu_irq), 32'h4, "trigger holds with low line");
    put(0, 1, 12'h0C1, 32'h100); step("R4");
    chk("R4", 32'(cpu_irq), 32'h0, "trigger cleared");

    irq_lines[10] = 1'b1; irq_lines[20] = 1'b1;
    put(0, 1, 12'h10A, 2); put(1, 1, 12'h114, 2); put(2, 1, 12'h040, 32'h0010_0400);
    step("R5");
    put(0, 1, 12'h811, 2); step("R8");
    chk("R8", 32'(cpu_irq[1]), 1, "IPI 1 raises CPU1");
    put(1, 0, 12'h400, 0); step("R6");
    chk("R6", rd(1), 32'h0004_0001, "IPI before hardware");
    put(1, 0, 12'h400, 0); step("R6");
    chk("R6", rd(1), 32'h0001_000A, "lower number first");
    put(1, 0, 12'h400, 0); step("R6");
    chk("R6", rd(1), 32'h0001_0014, "then source 20");
    put(1, 0, 12'h400, 0); step("R6");
    chk("R6", rd(1), 32'h0, "nothing pending");
    put(1, 0, 12'h403, 0); put(2, 0, 12'h811, 0); step("R8");
    chk("R8", rd(1), 32'h2, "IPI mask set by ack");
    chk("R8", rd(2), 32'h0, "IPI pending cleared by ack");

    irq_lines[7] = 1'b1;
    put(0, 1, 12'h107, 32'hF); put(1, 1, 12'h040, 32'h80); step("R5");
    put(0, 0, 12'h400, 0); put(1, 0, 12'h400, 0); step("R9");
    chk("R9", rd(0), 32'h0001_0007, "port 0 wins shared source");
    chk("R9", rd(1), 32'h0, "port 1 gets nothing");

    irq_lines[30] = 1'b1;
    put(0, 1, 12'h11E, 0); put(1, 1, 12'h040, 32'h4000_0000); step("R5");
    chk("R5", 32'(cpu_irq), 32'h0, "empty routing set");
    put(0, 0, 12'h850, 0); step("R10");
    chk("R10", rd(0), 32'h0, "window of absent CPU");
    put(0, 1, 12'h040, 32'h4000_0000); put(1, 1, 12'h000, 32'h4000_0000); step("R2");
    put(0, 0, 12'h000, 0); step("R2");
    chk("R2", 32'(rd(0)[30]), 1, "set wins over clear");

    put(0, 1, 12'h040, 32'h8); step("R3");
    chk("R3", 32'(cpu_irq[0]), 1, "line 3 pending again");
    irq_lines[3] = 1'b0;
    #1;
    chk("R3", 32'(cpu_irq[0]), 0, "output follows falling line");

    for (int k = 0; k < 6000; k++) begin
      irq_lines = {$urandom, $urandom} & {$urandom, $urandom};
      for (int p = 0; p < NC; p++) begin
        int op;
        logic [31:0] d;
        logic [11:0] win;
        if ($urandom % 10 < 4) continue;
        op = $urandom % 10;
        d = $urandom & $urandom;
        win = ($urandom % 2) ? 12'h400 : (12'h800 | 12'(($urandom % 6) << 4));
        case (op)
          0: put(p, 1, 12'h000 | 12'($urandom % 3), d);
          1, 2: put(p, 1, 12'h040 | 12'($urandom % 2), $urandom);
          3: put(p, 1, 12'h080 | 12'($urandom % 2) | 12'(($urandom % 2) << 6), d);
          4: put(p, 1, 12'h100 | 12'($urandom % 70), $urandom);
          5: put(p, 1, win | 12'(1 + $urandom % 4), $urandom);
          6: put(p, 0, 12'($urandom % 3) << 6 | 12'($urandom % 2), 0);
          7: put(p, 0, 12'h100 | 12'($urandom % 70), 0);
          default: put(p, 0, win | 12'(($urandom % 3 == 0) ? $urandom % 6 : 0), 0);
        endcase
      end
      step("R6");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule